// File: doc/BRIEF.md
# I2C Master Byte Controller

This block is a byte-at-a-time I2C bus master behind a small register file. Software fills a data register, picks transmit or receive through a mode field and writes a start command. The controller then produces the START condition, sends the data register byte as the address (the least significant bit is the direction, 1 for read), and moves one byte at a time. The SCL rate comes from a divide-by-16 or divide-by-512 prescaler followed by a 4-bit divisor. SCL and SDA are open-drain: each has an output enable that pulls the line low, and each line is read back.

After every byte, the address byte included, the controller samples the acknowledge bit, sets a pending flag and holds SCL low. It stays there until software writes the flag to zero. While the flag is set, software may load the next byte, request a STOP, or request a repeated START in a new mode. In receive mode the controller answers each byte with ACK or NACK according to an enable bit. Software clears that bit before the last byte so that the last byte gets a NACK.

The register addresses are 0 for control, 1 for status and mode, 2 for data, and 3 for a stored own-address byte. The own-address byte is only kept and read back.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, reads of the control (address 0), status (address 1) and data (address 2) registers return 0, sclOe and sdaOe are 0 and irq is 0.
- R2: A status write with bit 5 = 1 and bit 4 = 1 while the bus is idle produces a START, in which SDA falls while SCL is high. The data register byte is then sent MSB first as the address, and status bit 5 reads 1 while the bus is held. A status write with bit 4 = 0 starts nothing.
- R3: Each byte takes nine SCL clocks. After the ninth clock, control bit 4 (pending) becomes 1 and SCL is held low, and no further SCL clock occurs until software writes control bit 4 as 0. Writing control bit 4 as 1 leaves the flag unchanged.
- R4: Status bit 0 holds the SDA level sampled in the ninth clock of the last byte: 0 for ACK, 1 for NACK.
- R5: With status bits [7:6] = 2'b11, each byte after the address is taken from the data register. With 2'b10, each byte after the address is shifted into the data register MSB first and can be read there once pending is set.
- R6: In receive mode the ninth clock of a data byte carries ACK (SDA low) when control bit 7 is 1 and NACK (SDA released) when it is 0.
- R7: A status write with bit 5 = 0 while the bus is held produces a STOP once pending is cleared, in which SDA rises while SCL is high. Status bit 5 then reads 0 and both output enables are 0.
- R8: A status write with bit 5 = 1 while the bus is held produces a repeated START once pending is cleared, followed by the current data register byte as the address.
- R9: The SCL period is P x (D + 1) clock cycles, where D is control bits [3:0] and P is 16 when control bit 6 is 0 and 512 when it is 1.
- R10: irq equals control bit 4 AND control bit 5 (interrupt enable).
- R11: Apart from START and STOP, SDA changes only while SCL is low.
- R12: While a device holds SCL low after the controller has released it, the high phase does not begin. The byte then finishes normally once SCL is freed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 own address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr (combinational) |
| irq | output | 1 | Interrupt request |
| sclOe | output | 1 | Pulls SCL low when 1 |
| sclIn | input | 1 | Sampled SCL line |
| sdaOe | output | 1 | Pulls SDA low when 1 |
| sdaIn | input | 1 | Sampled SDA line |

## Verification
A bus-level device model acknowledges or refuses addresses, logs each received byte and supplies two distinct read bytes. This exercises a write transfer with several data bytes, a refused address, and a write-then-repeated-START read that ends with a NACK. These patterns separate transmit from receive shifting, ACK from NACK in both directions, and STOP from repeated START. SCL periods are measured with two prescaler and divisor settings, which exposes a wrong divisor or prescale choice. Holding SCL low from the device side, and waiting with pending set, shows that no clock escapes in either case.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_HOLD,
    ST_STOP
  } busState_t;

  // strobes from the sequencer to the register/datapath side
  typedef struct packed {
    logic sdaLoad;     // update the SDA pull-down register
    logic sdaLowVal;   // value for it (1 pulls low)
    logic shiftIn;     // shift sampled SDA into the data register
    logic ackCapture;  // store sampled SDA as the ack status
    logic pendSet;     // byte finished
    logic startTaken;  // start request consumed
    logic stopTaken;   // stop request consumed
  } laneStrobe_t;

endpackage

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
#(
  parameter int PRE_SLOW = 16,
  parameter int PRE_FAST = 512
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regAddr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  input  laneStrobe_t stb,
  input  logic        busy,
  input  logic        sdaIn,
  output logic        tick,
  output logic        pend,
  output logic        rxMode,
  output logic        ackEn,
  output logic        startReq,
  output logic        stopReq,
  output logic        dataMsb,
  output logic        sdaOe,
  output logic        irq
);
  localparam int DIV_W   = 4;
  localparam int SLOW_Q  = PRE_SLOW / 4;
  localparam int FAST_Q  = PRE_FAST / 4;
  localparam int PCNT_W  = $clog2(FAST_Q);
  localparam logic [PCNT_W-1:0] SLOW_LIM = PCNT_W'(SLOW_Q - 1);
  localparam logic [PCNT_W-1:0] FAST_LIM = PCNT_W'(FAST_Q - 1);

  logic             preFast, irqEn, xferEn, lastNack, sdaLowQ;
  logic [DIV_W-1:0] divSel, divCnt;
  logic [1:0]       mode;
  logic [7:0]       dataReg, ownAddr;
  logic [PCNT_W-1:0] preCnt, preLim;
  logic             preWrap, divDone;

  // register file and byte shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackEn <= 1'b0; preFast <= 1'b0; irqEn <= 1'b0; pend <= 1'b0;
      divSel <= '0; mode <= 2'b00; xferEn <= 1'b0; lastNack <= 1'b0;
      dataReg <= '0; ownAddr <= '0; startReq <= 1'b0; stopReq <= 1'b0;
      sdaLowQ <= 1'b0;
    end else begin
      if (regWe) begin
        case (regAddr)
          2'd0: begin
            ackEn   <= regWdata[7];
            preFast <= regWdata[6];
            irqEn   <= regWdata[5];
            if (!regWdata[4]) pend <= 1'b0;
            divSel  <= regWdata[3:0];
          end
          2'd1: begin
            mode   <= regWdata[7:6];
            xferEn <= regWdata[4];
            if (regWdata[5] && regWdata[4]) startReq <= 1'b1;
            if (!regWdata[5] && busy) stopReq <= 1'b1;
          end
          2'd2:    dataReg <= regWdata;
          default: ownAddr <= regWdata;
        endcase
      end
      if (stb.pendSet)    pend <= 1'b1;
      if (stb.startTaken) startReq <= 1'b0;
      if (stb.stopTaken) begin
        stopReq  <= 1'b0;
        startReq <= 1'b0;
      end
      if (stb.shiftIn)    dataReg <= {dataReg[6:0], sdaIn};
      if (stb.ackCapture) lastNack <= sdaIn;
      if (stb.sdaLoad)    sdaLowQ <= stb.sdaLowVal;
    end
  end

  // quarter-period tick: prescaler then divisor
  assign preLim  = preFast ? FAST_LIM : SLOW_LIM;
  assign preWrap = (preCnt == preLim);
  assign divDone = (divCnt >= divSel);
  assign tick    = preWrap && divDone;

  always_ff @(posedge clk) begin
    if (!rstN || !busy) begin
      preCnt <= '0;
      divCnt <= '0;
    end else begin
      preCnt <= preWrap ? '0 : preCnt + 1'b1;
      if (preWrap) divCnt <= divDone ? '0 : divCnt + 1'b1;
    end
  end

  always_comb begin
    case (regAddr)
      2'd0:    regRdata = {ackEn, preFast, irqEn, pend, divSel};
      2'd1:    regRdata = {mode, busy, xferEn, 3'b000, lastNack};
      2'd2:    regRdata = dataReg;
      default: regRdata = ownAddr;
    endcase
  end

  assign rxMode  = (mode == 2'b10);
  assign dataMsb = dataReg[7];
  assign sdaOe   = sdaLowQ;
  assign irq     = pend & irqEn;

endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        pend,
  input  logic        rxMode,
  input  logic        ackEn,
  input  logic        startReq,
  input  logic        stopReq,
  input  logic        dataMsb,
  input  logic        sclIn,
  output laneStrobe_t stb,
  output logic        busy,
  output logic        inBit,
  output logic        sclOe
);
  busState_t   state, stNext;
  logic [1:0]  phase, phaseNext;
  logic [3:0]  bitCnt, bitNext;
  logic        addrPhase, addrNext;

  // SDA pull-down for the next bit slot
  function automatic logic bitDrive(input logic isAddr, input logic isAck,
                                    input logic rx, input logic ackOn,
                                    input logic msb);
    if (isAck) return (rx && !isAddr) ? ackOn : 1'b0;
    return (rx && !isAddr) ? 1'b0 : !msb;
  endfunction

  always_comb begin
    stNext    = state;
    phaseNext = phase;
    bitNext   = bitCnt;
    addrNext  = addrPhase;
    stb       = '0;
    case (state)
      ST_IDLE: if (startReq) begin
        stNext = ST_START; phaseNext = 2'd1; addrNext = 1'b1;
        stb.startTaken = 1'b1; stb.sdaLoad = 1'b1; stb.sdaLowVal = 1'b0;
      end
      ST_START: if (tick) begin
        case (phase)
          2'd0: phaseNext = 2'd1;
          2'd1: if (sclIn) begin
            phaseNext = 2'd2; stb.sdaLoad = 1'b1; stb.sdaLowVal = 1'b1;
          end
          2'd2: phaseNext = 2'd3;
          default: begin
            stNext = ST_BIT; phaseNext = 2'd0; bitNext = 4'd0;
            stb.sdaLoad = 1'b1;
            stb.sdaLowVal = bitDrive(1'b1, 1'b0, rxMode, ackEn, dataMsb);
          end
        endcase
      end
      ST_BIT: if (tick) begin
        case (phase)
          2'd0: phaseNext = 2'd1;
          2'd1: if (sclIn) phaseNext = 2'd2;
          2'd2: begin
            phaseNext = 2'd3;
            if (bitCnt == 4'd8) stb.ackCapture = 1'b1;
            else                stb.shiftIn = 1'b1;
          end
          default: begin
            if (bitCnt == 4'd8) begin
              stNext = ST_HOLD; stb.pendSet = 1'b1;
            end else begin
              bitNext = bitCnt + 4'd1; phaseNext = 2'd0; stb.sdaLoad = 1'b1;
              stb.sdaLowVal = bitDrive(addrPhase, bitCnt == 4'd7, rxMode, ackEn, dataMsb);
            end
          end
        endcase
      end
      ST_HOLD: if (tick && !pend) begin
        phaseNext = 2'd0; stb.sdaLoad = 1'b1;
        if (stopReq) begin
          stNext = ST_STOP; stb.stopTaken = 1'b1; stb.sdaLowVal = 1'b1;
        end else if (startReq) begin
          stNext = ST_START; stb.startTaken = 1'b1; addrNext = 1'b1;
          stb.sdaLowVal = 1'b0;
        end else begin
          stNext = ST_BIT; bitNext = 4'd0; addrNext = 1'b0;
          stb.sdaLowVal = bitDrive(1'b0, 1'b0, rxMode, ackEn, dataMsb);
        end
      end
      ST_STOP: if (tick) begin
        case (phase)
          2'd0: phaseNext = 2'd1;
          2'd1: if (sclIn) begin
            phaseNext = 2'd2; stb.sdaLoad = 1'b1; stb.sdaLowVal = 1'b0;
          end
          default: begin stNext = ST_IDLE; phaseNext = 2'd0; end
        endcase
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; phase <= 2'd0; bitCnt <= 4'd0; addrPhase <= 1'b0;
    end else begin
      state <= stNext; phase <= phaseNext; bitCnt <= bitNext; addrPhase <= addrNext;
    end
  end

  always_comb begin
    case (state)
      ST_START, ST_BIT: sclOe = (phase == 2'd0) || (phase == 2'd3);
      ST_HOLD:          sclOe = 1'b1;
      ST_STOP:          sclOe = (phase == 2'd0);
      default:          sclOe = 1'b0;
    endcase
  end

  assign busy  = (state != ST_IDLE);
  assign inBit = (state == ST_BIT);

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int PRE_SLOW = 16,
  parameter int PRE_FAST = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       irq,
  output logic       sclOe,
  input  logic       sclIn,
  output logic       sdaOe,
  input  logic       sdaIn
);
  laneStrobe_t stbS;
  logic tickS, pendS, rxModeS, ackEnS, startReqS, stopReqS, dataMsbS, busyS, inBitS;

  i2cm_regs #(.PRE_SLOW(PRE_SLOW), .PRE_FAST(PRE_FAST)) u_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .stb(stbS), .busy(busyS),
    .sdaIn(sdaIn), .tick(tickS), .pend(pendS), .rxMode(rxModeS),
    .ackEn(ackEnS), .startReq(startReqS), .stopReq(stopReqS),
    .dataMsb(dataMsbS), .sdaOe(sdaOe), .irq(irq)
  );

  i2cm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tickS), .pend(pendS), .rxMode(rxModeS),
    .ackEn(ackEnS), .startReq(startReqS), .stopReq(stopReqS),
    .dataMsb(dataMsbS), .sclIn(sclIn), .stb(stbS), .busy(busyS),
    .inBit(inBitS), .sclOe(sclOe)
  );

endmodule

// File: rtl/i2cm_checks.sv
module i2cm_checks (
  input logic       clk,
  input logic       rstN,
  input logic       sclOe,
  input logic       sdaOe,
  input logic       pend,
  input logic       inBit,
  input logic       busy,
  input logic       startReq,
  input logic       regWe,
  input logic [1:0] regAddr,
  input logic [7:0] regWdata
);
  AST_PEND_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rstN)
    pend |-> sclOe);  // R3

  AST_PEND_AFTER_BIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pend) |-> $past(inBit));  // R3

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (inBit && $past(inBit) && !sclOe && !$past(sclOe)) |-> $stable(sdaOe));  // R11

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 2'd1 && !regWdata[4] && !busy && !startReq) |=> !busy);  // R2

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (!sclOe && !sdaOe));  // R7

endmodule

bind i2c_byte_master i2cm_checks u_chk (
  .clk(clk), .rstN(rstN), .sclOe(sclOe), .sdaOe(sdaOe), .pend(pendS),
  .inBit(inBitS), .busy(busyS), .startReq(startReqS), .regWe(regWe),
  .regAddr(regAddr), .regWdata(regWdata)
);

// File: tb/tb_i2c_byte_master.sv
`timescale 1ns/1ps
module tb_i2c_byte_master;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic       irq, sclOe, sdaOe;
  logic       slvLow = 1'b0;
  logic       stretch = 1'b0;
  logic       ackEnable = 1'b1;

  wire sclLine = !(sclOe || stretch);
  wire sdaLine = !(sdaOe || slvLow);

  always #2 clk = ~clk;  // 250 MHz

  i2c_byte_master dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .sclOe(sclOe),
    .sclIn(sclLine), .sdaOe(sdaOe), .sdaIn(sdaLine)
  );

  int checks = 0;
  int fails = 0;
  longint cyc = 0;
  bit done = 0;

  // ---------------- bus device model ----------------
  int rise = 0, riseCount = 0, startCount = 0, stopCount = 0, txIdx = 0;
  logic [7:0] shiftIn = 8'd0, lastRx = 8'd0, byteNow;
  bit inAddr = 0, sending = 0, masterNack = 0, pScl = 1, pSda = 1;
  longint t1 = 0, t2 = 0;

  function automatic logic [7:0] slvByte(input int idx);
    return 8'hA5 ^ (8'(idx) * 8'h99);
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rstN) begin
      if (pScl && sclLine && pSda && !sdaLine) begin
        startCount++; rise = 0; inAddr = 1; sending = 0; slvLow <= 1'b0;
      end else if (pScl && sclLine && !pSda && sdaLine) begin
        stopCount++; sending = 0; slvLow <= 1'b0;
      end else if (!pScl && sclLine) begin
        riseCount++;
        if (rise == 1) t1 = cyc;
        if (rise == 2) t2 = cyc;
        if (rise < 8) shiftIn = {shiftIn[6:0], sdaLine};
        else if (sending) masterNack = sdaLine;
        rise++;
      end else if (pScl && !sclLine) begin
        if (rise == 8) begin
          if (!sending) begin slvLow <= ackEnable; lastRx = shiftIn; end
          else slvLow <= 1'b0;
        end else if (rise == 9) begin
          rise = 0;
          if (inAddr) begin
            inAddr = 0;
            sending = shiftIn[0] && ackEnable;
            byteNow = slvByte(txIdx);
            slvLow <= sending ? !byteNow[7] : 1'b0;
          end else if (sending && !masterNack) begin
            txIdx++;
            byteNow = slvByte(txIdx);
            slvLow <= !byteNow[7];
          end else begin
            sending = 0; slvLow <= 1'b0;
          end
        end else if (rise >= 1 && rise <= 7 && sending) begin
          byteNow = slvByte(txIdx);
          slvLow <= !byteNow[7-rise];
        end
      end
      pScl = sclLine;
      pSda = sdaLine;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata;
  endtask

  task automatic waitPend(input string tag);
    logic [7:0] v;
    for (int i = 0; i < 20000; i++) begin
      rdReg(2'd0, v);
      if (v[4]) return;
    end
    check({tag, " pending timeout"}, 0, 1);
  endtask

  task automatic waitIdle(input string tag);
    logic [7:0] v;
    for (int i = 0; i < 20000; i++) begin
      rdReg(2'd1, v);
      if (!v[5]) return;
    end
    check({tag, " idle timeout"}, 0, 1);
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    logic [7:0] v;
    rdReg(2'd0, v); check("R1 ctrl", v, 0);
    rdReg(2'd1, v); check("R1 status", v, 0);
    rdReg(2'd2, v); check("R1 data", v, 0);
    check("R1 sclOe", sclOe, 0);
    check("R1 sdaOe", sdaOe, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic testDisabledStart();
    logic [7:0] v;
    wrReg(2'd1, 8'hE0);
    repeat (60) @(negedge clk);
    rdReg(2'd1, v); check("R2 no start when disabled busy", v[5], 0);
    check("R2 no start when disabled bus", startCount, 0);
  endtask

  task automatic testWrite();
    logic [7:0] v;
    int rc, s0, p0;
    s0 = startCount; p0 = stopCount;
    wrReg(2'd0, 8'hA1);
    wrReg(2'd2, 8'hA0);
    wrReg(2'd1, 8'hF0);
    waitPend("R2");
    rdReg(2'd1, v);
    check("R2 busy bit", v[5], 1);
    check("R4 address ack", v[0], 0);
    check("R2 address byte", lastRx, 8'hA0);
    check("R2 one start", startCount - s0, 1);
    check("R9 scl period /16 div1", t2 - t1, 32);
    check("R10 irq on", irq, 1);
    rc = riseCount;
    repeat (200) @(negedge clk);
    check("R3 no clock while pending", riseCount, rc);
    check("R3 scl held low", sclLine, 0);
    wrReg(2'd0, 8'hB1);
    rdReg(2'd0, v); check("R3 writing 1 keeps pending", v[4], 1);
    wrReg(2'd2, 8'h5A);
    wrReg(2'd0, 8'hA1);
    waitPend("R5");
    check("R5 transmit byte", lastRx, 8'h5A);
    check("R3 nine clocks per byte", riseCount - rc, 9);
    wrReg(2'd0, 8'h91);
    check("R10 irq masked", irq, 0);
    rdReg(2'd0, v); check("R10 pending still set", v[4], 1);
    wrReg(2'd2, 8'h33);
    stretch = 1'b1;
    rc = riseCount;
    wrReg(2'd0, 8'h81);
    repeat (300) @(negedge clk);
    check("R12 stretched scl no rise", riseCount, rc);
    stretch = 1'b0;
    waitPend("R12");
    check("R12 byte after stretch", lastRx, 8'h33);
    wrReg(2'd1, 8'hD0);
    wrReg(2'd0, 8'hA1);
    waitIdle("R7");
    check("R7 one stop", stopCount - p0, 1);
    check("R7 scl released", sclOe, 0);
    check("R7 sda released", sdaOe, 0);
    check("R11 no extra start", startCount - s0, 1);
  endtask

  task automatic testNack();
    logic [7:0] v;
    ackEnable = 1'b0;
    wrReg(2'd0, 8'hA0);
    wrReg(2'd2, 8'h90);
    wrReg(2'd1, 8'hF0);
    waitPend("R4");
    rdReg(2'd1, v); check("R4 nack seen", v[0], 1);
    wrReg(2'd1, 8'hD0);
    wrReg(2'd0, 8'hA0);
    waitIdle("R7");
    ackEnable = 1'b1;
  endtask

  task automatic testRead();
    logic [7:0] v;
    int s0, p0;
    s0 = startCount; p0 = stopCount; txIdx = 0;
    wrReg(2'd0, 8'hA0);
    wrReg(2'd2, 8'hA0);
    wrReg(2'd1, 8'hF0);
    waitPend("R8");
    wrReg(2'd2, 8'h10);
    wrReg(2'd0, 8'hA0);
    waitPend("R8");
    wrReg(2'd2, 8'hA1);
    wrReg(2'd1, 8'hB0);
    wrReg(2'd0, 8'hA0);
    waitPend("R8");
    check("R8 repeated start", startCount - s0, 2);
    check("R8 new address byte", lastRx, 8'hA1);
    check("R8 no stop between", stopCount - p0, 0);
    wrReg(2'd0, 8'hA0);
    waitPend("R5");
    rdReg(2'd2, v); check("R5 received byte 1", v, 8'hA5);
    check("R6 ack sent", masterNack, 0);
    wrReg(2'd0, 8'h20);
    waitPend("R5");
    rdReg(2'd2, v); check("R5 received byte 2", v, 8'h3C);
    check("R6 nack sent", masterNack, 1);
    wrReg(2'd1, 8'h90);
    wrReg(2'd0, 8'h20);
    waitIdle("R7");
    check("R7 stop after read", stopCount - p0, 1);
  endtask

  task automatic testPrescale();
    wrReg(2'd0, 8'hE0);
    wrReg(2'd2, 8'hA0);
    wrReg(2'd1, 8'hF0);
    waitPend("R9");
    check("R9 scl period /512 div0", t2 - t1, 512);
    wrReg(2'd1, 8'hD0);
    wrReg(2'd0, 8'hE0);
    waitIdle("R9");
  endtask

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!done && cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finishRun();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testDisabledStart();
    testWrite();
    testNack();
    testRead();
    testPrescale();
    finishRun();
  end

endmodule